// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt requests and presents one winner to the processor as an interrupt level and a vector number. Each source has a mask bit and an 8-bit priority control byte. A zero control byte disables the source. Software can also force any source active through a force register. A source takes part in arbitration when it is pending or forced, enabled and unmasked. The source with the largest control value wins. On equal values the higher-numbered source wins.

Software reaches the block through a plain synchronous register bus on a 256-byte window. Reads are combinational on the address and have no side effects. A write takes effect at the clock edge on which the write enable is high. The window holds several registers: pending words, which are read-only; mask words; force words; byte-wide commands that set or clear one mask bit or all of them; one control byte per source; and a software acknowledge location that returns the current vector. The level and vector outputs are registered. No handshake is involved: the outputs are plain status pins that follow the arbitration result.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, cpu_level is 0 and cpu_vector is 24. Both mask words read 0xFFFFFFFF. The pending words, the force words and every control byte read 0.
- R2: Each request input is copied into its pending bit at every clock edge, with bit n of the 64-bit pending vector at source n. Offset 0x00 reads bits 63:32 and offset 0x04 reads bits 31:0. Writes to these two offsets have no effect.
- R3: A source is active when (pending OR forced) AND enabled AND NOT masked. A source is enabled exactly when its control byte is nonzero. The control byte of source n is written and read at offset 0x40+n, using data bits 7:0.
- R4: Among the active sources, the one with the largest control value wins. On equal values the higher source index wins.
- R5: When there is a winner, cpu_vector is 64 plus the winner's index. When no source is active, cpu_vector is 24 and cpu_level is 0.
- R6: cpu_level equals the winner's control value, saturated at 7. Arbitration compares the full 8-bit values, so 255 beats 200.
- R7: The mask words are read and written at offset 0x08 (bits 63:32) and offset 0x0C (bits 31:0). A mask bit of 1 blocks its source.
- R8: A write to offset 0x1C with data bit 6 set masks all sources. With bit 6 clear, it sets the single mask bit selected by data bits 5:0.
- R9: A write to offset 0x1D with data bit 6 set unmasks all sources. With bit 6 clear, it clears the single mask bit selected by data bits 5:0.
- R10: The force words are read and written at offset 0x10 (bits 63:32) and offset 0x14 (bits 31:0). A forced source competes exactly like a pending one.
- R11: A read of offset 0xE0 returns the current cpu_vector, zero-extended to 32 bits.
- R12: Any offset not listed above reads 0. Writes to such offsets change no state.
- R13: A change to the mask, force or control state shows on cpu_level and cpu_vector at the clock edge after the edge that stored it. A change on a request input shows two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 64 | Level-sensitive requests, bit n is source n |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_level | output | 3 | Registered interrupt level, 0 when idle |
| cpu_vector | output | 8 | Registered vector number |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit control bytes, a 3-bit level, vector base 64 and idle vector 24. These values put both ends of the source range in reach: source 0 gives vector 64 and source 63 gives vector 127. A tie at source 63 exercises the highest-index rule at the top of the tree. Control values above 7 exercise the saturated level, and the case where 255 beats 200 shows that the comparison uses the full 8 bits. The bench also covers the mask-all and unmask-all commands on the full 64-bit mask, and the two-edge latency from a request input.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MSET     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MCLR     = 8'h1D;
  localparam logic [ADDR_W-1:0] OFS_SWACK    = 8'hE0;
  localparam logic [1:0]        CTRL_PAGE    = 2'b01;  // 0x40..0x7F
  localparam int unsigned       ALL_BIT      = 6;      // mask-all / unmask-all flag
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned PRI_W = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_req,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [VEC_W-1:0]      cur_vector,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NSRC-1:0]       act,
  output logic [NSRC*PRI_W-1:0] pri_flat
);
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned HALF  = NSRC / 2;

  logic [NSRC-1:0]  pend_q, mask_q, mask_d, force_q;
  logic [PRI_W-1:0] pri_q [NSRC];
  logic             ctrl_hit;
  logic [IDX_W-1:0] ctrl_idx, sel_idx;

  assign ctrl_hit = (bus_addr[7:6] == CTRL_PAGE);
  assign ctrl_idx = bus_addr[IDX_W-1:0];
  assign sel_idx  = bus_wdata[IDX_W-1:0];

  // Pending follows the request levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_req;
  end

  // Mask next-state: word writes plus the byte set/clear commands.
  always_comb begin
    mask_d = mask_q;
    if (bus_we) begin
      case (bus_addr)
        OFS_MASK_HI: mask_d[NSRC-1:HALF] = bus_wdata[HALF-1:0];
        OFS_MASK_LO: mask_d[HALF-1:0]    = bus_wdata[HALF-1:0];
        OFS_MSET: begin
          if (bus_wdata[ALL_BIT]) mask_d = '1;
          else                    mask_d[sel_idx] = 1'b1;
        end
        OFS_MCLR: begin
          if (bus_wdata[ALL_BIT]) mask_d = '0;
          else                    mask_d[sel_idx] = 1'b0;
        end
        default: mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      force_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (bus_we && bus_addr == OFS_FORCE_HI) force_q[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
      if (bus_we && bus_addr == OFS_FORCE_LO) force_q[HALF-1:0]    <= bus_wdata[HALF-1:0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pri_q[i] <= '0;
      else if (bus_we && ctrl_hit && ctrl_idx == IDX_W'(i))
        pri_q[i] <= bus_wdata[PRI_W-1:0];
    end
    assign act[i] = (pend_q[i] | force_q[i]) & (|pri_q[i]) & ~mask_q[i];
    assign pri_flat[i*PRI_W +: PRI_W] = pri_q[i];
  end

  always_comb begin
    case (bus_addr)
      OFS_PEND_HI:  bus_rdata = DATA_W'(pend_q[NSRC-1:HALF]);
      OFS_PEND_LO:  bus_rdata = DATA_W'(pend_q[HALF-1:0]);
      OFS_MASK_HI:  bus_rdata = DATA_W'(mask_q[NSRC-1:HALF]);
      OFS_MASK_LO:  bus_rdata = DATA_W'(mask_q[HALF-1:0]);
      OFS_FORCE_HI: bus_rdata = DATA_W'(force_q[NSRC-1:HALF]);
      OFS_FORCE_LO: bus_rdata = DATA_W'(force_q[HALF-1:0]);
      OFS_SWACK:    bus_rdata = DATA_W'(cur_vector);
      default:      bus_rdata = ctrl_hit ? DATA_W'(pri_q[ctrl_idx]) : '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned PRI_W = 8,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       act,
  input  logic [NSRC*PRI_W-1:0] pri_flat,
  output logic                  win_vld,
  output logic [IDX_W-1:0]      win_idx,
  output logic [PRI_W-1:0]      win_pri
);
  // Heap-ordered tree: node k has children 2k (lower indices) and 2k+1 (higher).
  logic             nv [1:2*NSRC-1];
  logic [PRI_W-1:0] np [1:2*NSRC-1];
  logic [IDX_W-1:0] ni [1:2*NSRC-1];

  for (genvar i = 0; i < NSRC; i++) begin : g_leaf
    assign nv[NSRC+i] = act[i];
    assign np[NSRC+i] = pri_flat[i*PRI_W +: PRI_W];
    assign ni[NSRC+i] = IDX_W'(i);
  end

  for (genvar k = 1; k < NSRC; k++) begin : g_node
    logic take_hi;
    // Ties go to the higher-index child.
    assign take_hi = nv[2*k+1] && (!nv[2*k] || np[2*k+1] >= np[2*k]);
    assign nv[k]   = nv[2*k] | nv[2*k+1];
    assign np[k]   = take_hi ? np[2*k+1] : np[2*k];
    assign ni[k]   = take_hi ? ni[2*k+1] : ni[2*k];
  end

  assign win_vld = nv[1];
  assign win_idx = ni[1];
  assign win_pri = np[1];
endmodule

// File: rtl/irq_prio_out.sv
module irq_prio_out #(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned PRI_W    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24,
  localparam int unsigned IDX_W   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [PRI_W-1:0] win_pri,
  output logic [LVL_W-1:0] cpu_level,
  output logic [VEC_W-1:0] cpu_vector
);
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;

  assign lvl_d = !win_vld ? '0 :
                 (win_pri > PRI_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : win_pri[LVL_W-1:0];
  assign vec_d = win_vld ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : VEC_W'(VEC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_level  <= '0;
      cpu_vector <= VEC_W'(VEC_IDLE);
    end else begin
      cpu_level  <= lvl_d;
      cpu_vector <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned PRI_W    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LVL_W-1:0]  cpu_level,
  output logic [VEC_W-1:0]  cpu_vector
);
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]       act;
  logic [NSRC*PRI_W-1:0] pri_flat;
  logic                  win_vld;
  logic [IDX_W-1:0]      win_idx;
  logic [PRI_W-1:0]      win_pri;

  irq_prio_regs #(.NSRC(NSRC), .PRI_W(PRI_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .cur_vector(cpu_vector), .bus_rdata(bus_rdata),
    .act(act), .pri_flat(pri_flat)
  );

  irq_prio_arb #(.NSRC(NSRC), .PRI_W(PRI_W)) u_arb (
    .act(act), .pri_flat(pri_flat),
    .win_vld(win_vld), .win_idx(win_idx), .win_pri(win_pri)
  );

  irq_prio_out #(
    .NSRC(NSRC), .PRI_W(PRI_W), .LVL_W(LVL_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .win_vld(win_vld), .win_idx(win_idx), .win_pri(win_pri),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [LVL_W-1:0] cpu_level,
  input logic [VEC_W-1:0] cpu_vector
);
  logic mapped;
  always_comb begin
    case (bus_addr)
      8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h1D, 8'hE0: mapped = 1'b1;
      default: mapped = (bus_addr[7:6] == 2'b01);
    endcase
  end

  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_level == '0 && cpu_vector == VEC_W'(VEC_IDLE)));

  a_r5_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vector == VEC_W'(VEC_IDLE)) ||
    (cpu_vector >= VEC_W'(VEC_BASE) && cpu_vector < VEC_W'(VEC_BASE + NSRC)));

  a_r5_idle_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vector == VEC_W'(VEC_IDLE)) |-> (cpu_level == '0));

  a_r6_winner_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vector != VEC_W'(VEC_IDLE)) |-> (cpu_level != '0));

  a_r8_mask_all_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h1C && bus_wdata[6]) |=> ##1 (cpu_vector == VEC_W'(VEC_IDLE)));

  a_r11_swack_reads_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'hE0) |-> (bus_rdata == 32'(cpu_vector)));

  a_r12_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cpu_level(cpu_level), .cpu_vector(cpu_vector)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  cpu_level;
  logic [7:0]  cpu_vector;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 8'h00;
  endtask

  task automatic settle;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic out_chk(input string tag, input logic [2:0] lvl, input logic [7:0] vec);
    chk({tag, " level"}, 32'(cpu_level), 32'(lvl));
    chk({tag, " vector"}, 32'(cpu_vector), 32'(vec));
  endtask

  task automatic t_reset;
    out_chk("R1 reset", 3'd0, 8'd24);
    rd_chk("R1 mask hi", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R1 mask lo", 8'h0C, 32'hFFFF_FFFF);
    rd_chk("R1 pend lo", 8'h04, 32'h0);
    rd_chk("R1 force hi", 8'h10, 32'h0);
    rd_chk("R1 ctrl 63", 8'h7F, 32'h0);
  endtask

  task automatic t_pending;
    irq_req = (64'd1 << 40) | (64'd1 << 5);
    settle();
    rd_chk("R2 pend hi", 8'h00, 32'h100);
    rd_chk("R2 pend lo", 8'h04, 32'h20);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    settle();
    rd_chk("R2 pend lo after write", 8'h04, 32'h20);
    rd_chk("R2 pend hi after write", 8'h00, 32'h100);
    out_chk("R3 masked and disabled", 3'd0, 8'd24);
  endtask

  task automatic t_enable;
    wr(8'h1D, 32'd5);
    settle();
    rd_chk("R9 clear bit 5", 8'h0C, 32'hFFFF_FFDF);
    out_chk("R3 zero ctrl disables", 3'd0, 8'd24);
    wr(8'h45, 32'd3);
    settle();
    out_chk("R3 enabled source 5", 3'd3, 8'd69);
  endtask

  task automatic t_ties;
    wr(8'h68, 32'd3);
    wr(8'h1D, 32'd40);
    settle();
    rd_chk("R9 clear bit 40", 8'h08, 32'hFFFF_FEFF);
    out_chk("R4 tie higher index", 3'd3, 8'd104);
    wr(8'h45, 32'd4);
    settle();
    out_chk("R4 larger value wins", 3'd4, 8'd69);
  endtask

  task automatic t_saturate;
    wr(8'h68, 32'd200);
    settle();
    out_chk("R6 saturate 200", 3'd7, 8'd104);
    wr(8'h45, 32'd255);
    settle();
    out_chk("R6 full compare 255", 3'd7, 8'd69);
    rd_chk("R6 ctrl readback", 8'h45, 32'd255);
  endtask

  task automatic t_timing;
    @(negedge clk);
    irq_req[5] = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_chk("R2 pend after one edge", 8'h04, 32'h0);
    out_chk("R13 one edge old winner", 3'd7, 8'd69);
    @(posedge clk); @(negedge clk);
    out_chk("R13 two edges new winner", 3'd7, 8'd104);
    wr(8'h1D, 32'd5);  // no-op on mask, ensures timing of state write
    @(posedge clk); #1;
    chk("R13 state write next edge", 32'(cpu_vector), 32'd104);
  endtask

  task automatic t_setclr;
    wr(8'h1C, 32'h40);
    rd_chk("R8 mask all hi", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R8 mask all lo", 8'h0C, 32'hFFFF_FFFF);
    @(posedge clk); @(negedge clk);
    out_chk("R8 mask all idle", 3'd0, 8'd24);
    wr(8'h1D, 32'h40);
    rd_chk("R9 unmask all hi", 8'h08, 32'h0);
    rd_chk("R9 unmask all lo", 8'h0C, 32'h0);
    settle();
    out_chk("R9 unmask all winner", 3'd7, 8'd104);
    wr(8'h1C, 32'd40);
    settle();
    rd_chk("R8 set bit 40", 8'h08, 32'h100);
    out_chk("R8 set bit 40 idle", 3'd0, 8'd24);
  endtask

  task automatic t_maskwords;
    wr(8'h0C, 32'h1234_5678);
    wr(8'h08, 32'h9ABC_DEF0);
    rd_chk("R7 mask lo", 8'h0C, 32'h1234_5678);
    rd_chk("R7 mask hi", 8'h08, 32'h9ABC_DEF0);
    wr(8'h1C, 32'h40);
  endtask

  task automatic t_force;
    irq_req = '0;
    wr(8'h14, 32'h4);
    wr(8'h42, 32'd1);
    wr(8'h1D, 32'd2);
    settle();
    out_chk("R10 forced source 2", 3'd1, 8'd66);
    rd_chk("R10 force lo", 8'h14, 32'h4);
    rd_chk("R10 force hi", 8'h10, 32'h0);
    wr(8'h10, 32'h8000_0000);
    wr(8'h7F, 32'd1);
    wr(8'h1D, 32'd63);
    settle();
    out_chk("R5 source 63 tie", 3'd1, 8'd127);
    rd_chk("R11 swack", 8'hE0, 32'd127);
  endtask

  task automatic t_unmapped;
    rd_chk("R12 read 0x18", 8'h18, 32'h0);
    rd_chk("R12 read 0x20", 8'h20, 32'h0);
    rd_chk("R12 read 0x80", 8'h80, 32'h0);
    rd_chk("R12 read 0xE4", 8'hE4, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'hE0, 32'h0);
    settle();
    out_chk("R12 writes ignored", 3'd1, 8'd127);
    rd_chk("R12 mask hi kept", 8'h08, 32'h7FFF_FFFF);
    rd_chk("R12 mask lo kept", 8'h0C, 32'hFFFF_FFFB);
    rd_chk("R12 force hi kept", 8'h10, 32'h8000_0000);
    rd_chk("R12 force lo kept", 8'h14, 32'h4);
  endtask

  task automatic t_source0;
    wr(8'h40, 32'd9);
    wr(8'h1D, 32'd0);
    irq_req[0] = 1'b1;
    settle();
    @(posedge clk); @(negedge clk);
    out_chk("R5 source 0 vector 64", 3'd7, 8'd64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_enable();
    t_ties();
    t_saturate();
    t_timing();
    t_setclr();
    t_maskwords();
    t_force();
    t_unmapped();
    t_source0();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule